// File: doc/BRIEF.md
# Lockable Thermal Register Bank

This block is the register file that sits behind the serial slave of a digital temperature sensor. It keeps eight 16-bit locations. There are three fixed identification words. There is one configuration word. There are three alarm thresholds: upper, lower and critical. There is one word that holds the latest converted temperature and its trip status. The bus slave reaches all of them through a single address/data port. Writes take effect at the clock edge, and reads are combinational from the current state.

Each configuration field follows its own write rule. Two lock bits can only be set, and only reset clears them. The alarm lock freezes the upper and lower thresholds, and the critical lock freezes the critical threshold. While either lock is held, the event-output settings and the hysteresis setting are frozen, and the sensor cannot be put into shutdown. Writing a one to the clear position produces a single-cycle strobe for the event logic, and that position always reads back as zero. The converter delivers 13-bit samples with trip flags from the comparison logic. The sample register holds the last one taken while the sensor is active.

Top module: `thermal_regbank`

## Requirements
- R1: After reset the reads are as follows. Address 0x00 reads 0x007F. 0x06 reads 0x1B09 and 0x07 reads 0x0813. 0x01 to 0x05 read 0x0000. Every address from 0x08 upward reads 0x0000.
- R2: A write to a threshold register (0x02 upper, 0x03 lower, 0x04 critical) stores only bits 12:2. Bits 15:13 and 1:0 always read 0.
- R3: Configuration bit 6 (alarm lock) can be set by a write but not cleared except by reset. While it is set, writes to 0x02 and 0x03 have no effect.
- R4: Configuration bit 7 (critical lock) can be set by a write but not cleared except by reset. While it is set, writes to 0x04 have no effect.
- R5: While either lock is set, configuration bits 10:9 (hysteresis), 3 (event enable), 1 (polarity) and 0 (interrupt mode) keep their values across writes.
- R6: Configuration bit 2 (critical-only) cannot go from 0 to 1 while the alarm lock is set, but it can still be cleared.
- R7: Configuration bit 8 (shutdown) cannot go from 0 to 1 while either lock is set, but it can be cleared at any time.
- R8: A write to 0x01 with bit 5 set drives event_clear_o high for exactly the cycle that follows the write edge. Bit 5 always reads 0.
- R9: Configuration bit 4 reads the level of event_active_i. Configuration bits 15:11 read 0 whatever was written.
- R10: When sample_valid_i is high and shutdown is clear, address 0x05 takes the following value at the next edge. Bit 15 is crit_trip_i, bit 14 is high_trip_i, bit 13 is low_trip_i, and bits 12:0 are sample_i.
- R11: While shutdown is set, samples are ignored and 0x05 keeps its last value.
- R12: Writes to 0x00, 0x05, 0x06, 0x07 and to addresses 0x08 and above change no readable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register address for read and write |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Read data of addr_i |
| sample_valid_i | input | 1 | New converter sample present |
| sample_i | input | 13 | Two's complement temperature sample |
| crit_trip_i | input | 1 | Sample at or above critical threshold |
| high_trip_i | input | 1 | Sample above upper threshold |
| low_trip_i | input | 1 | Sample below lower threshold |
| event_active_i | input | 1 | Current event-asserted state |
| hyst_o | output | 2 | Hysteresis selection |
| shutdown_o | output | 1 | Sensor shut down |
| crit_lock_o | output | 1 | Critical threshold locked |
| alarm_lock_o | output | 1 | Upper/lower thresholds locked |
| event_en_o | output | 1 | Event output enabled |
| crit_only_o | output | 1 | Events from critical crossing only |
| event_pol_o | output | 1 | Event polarity, 1 = active high |
| event_mode_o | output | 1 | 1 = interrupt mode, 0 = comparator |
| event_clear_o | output | 1 | One-cycle event clear strobe |
| high_limit_o | output | 16 | Upper threshold |
| low_limit_o | output | 16 | Lower threshold |
| crit_limit_o | output | 16 | Critical threshold |

## Verification
The assertions assume that wr_en_i is a single-cycle strobe. They also assume that addr_i is held steady while a read is sampled, and that every input is known once reset is released. The bench changes inputs only at the falling edge. It pulses wr_en_i for exactly one cycle and parks addr_i on the address it is about to read. It applies a fresh reset before each lock scenario, because only reset clears a lock.

// File: rtl/thermal_regbank_pkg.sv
package thermal_regbank_pkg;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 16;
  localparam int SAMPLE_W = 13;
  localparam int N_LIMITS = 3;

  localparam logic [ADDR_W-1:0] A_CAP  = 8'h00;
  localparam logic [ADDR_W-1:0] A_CFG  = 8'h01;
  localparam logic [ADDR_W-1:0] A_HIGH = 8'h02;
  localparam logic [ADDR_W-1:0] A_LOW  = 8'h03;
  localparam logic [ADDR_W-1:0] A_CRIT = 8'h04;
  localparam logic [ADDR_W-1:0] A_TEMP = 8'h05;
  localparam logic [ADDR_W-1:0] A_MFR  = 8'h06;
  localparam logic [ADDR_W-1:0] A_DEV  = 8'h07;

  localparam logic [DATA_W-1:0] CAP_VAL    = 16'h007F;
  localparam logic [DATA_W-1:0] MFR_VAL    = 16'h1B09;
  localparam logic [DATA_W-1:0] DEV_VAL    = 16'h0813;
  localparam logic [DATA_W-1:0] LIMIT_MASK = 16'h1FFC;

  typedef struct packed {
    logic [1:0] hyst;
    logic       shdn;
    logic       crit_lock;
    logic       alarm_lock;
    logic       ev_en;
    logic       crit_only;
    logic       ev_pol;
    logic       ev_mode;
  } cfg_t;
endpackage

// File: rtl/thermal_regbank_cfg.sv
module thermal_regbank_cfg
  import thermal_regbank_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wd_i,
  output cfg_t              cfg_o,
  output logic              clear_o
);
  cfg_t q, d;
  logic any_lock;

  assign any_lock = q.crit_lock | q.alarm_lock;

  always_comb begin
    d = q;
    if (wr_i) begin
      d.crit_lock  = q.crit_lock  | wd_i[7];
      d.alarm_lock = q.alarm_lock | wd_i[6];
      if (!any_lock) begin
        d.hyst    = wd_i[10:9];
        d.ev_en   = wd_i[3];
        d.ev_pol  = wd_i[1];
        d.ev_mode = wd_i[0];
      end
      // locks allow clearing only
      d.shdn      = any_lock     ? (q.shdn & wd_i[8])      : wd_i[8];
      d.crit_only = q.alarm_lock ? (q.crit_only & wd_i[2]) : wd_i[2];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q       <= '0;
      clear_o <= 1'b0;
    end else begin
      q       <= d;
      clear_o <= wr_i & wd_i[5];
    end
  end

  assign cfg_o = q;
endmodule

// File: rtl/thermal_regbank_limit.sv
module thermal_regbank_limit
  import thermal_regbank_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              lock_i,
  input  logic [DATA_W-1:0] wd_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             q_o <= '0;
    else if (wr_i && !lock_i) q_o <= wd_i & LIMIT_MASK;
  end
endmodule

// File: rtl/thermal_regbank_sample.sv
module thermal_regbank_sample
  import thermal_regbank_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic                shdn_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [2:0]          flags_i,
  output logic [DATA_W-1:0]   q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                q_o <= '0;
    else if (valid_i && !shdn_i) q_o <= {flags_i, sample_i};
  end
endmodule

// File: rtl/thermal_regbank.sv
module thermal_regbank
  import thermal_regbank_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_en_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  output logic [DATA_W-1:0]   rd_data_o,
  input  logic                sample_valid_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                crit_trip_i,
  input  logic                high_trip_i,
  input  logic                low_trip_i,
  input  logic                event_active_i,
  output logic [1:0]          hyst_o,
  output logic                shutdown_o,
  output logic                crit_lock_o,
  output logic                alarm_lock_o,
  output logic                event_en_o,
  output logic                crit_only_o,
  output logic                event_pol_o,
  output logic                event_mode_o,
  output logic                event_clear_o,
  output logic [DATA_W-1:0]   high_limit_o,
  output logic [DATA_W-1:0]   low_limit_o,
  output logic [DATA_W-1:0]   crit_limit_o
);
  cfg_t              cfg;
  logic [DATA_W-1:0] lim_q [N_LIMITS];
  logic [DATA_W-1:0] temp_q;
  logic [DATA_W-1:0] cfg_rd;

  thermal_regbank_cfg u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_en_i && addr_i == A_CFG),
    .wd_i   (wr_data_i),
    .cfg_o  (cfg),
    .clear_o(event_clear_o)
  );

  // limits at A_HIGH + i: high, low, crit
  for (genvar i = 0; i < N_LIMITS; i++) begin : g_lim
    localparam logic [ADDR_W-1:0] LADDR = A_HIGH + ADDR_W'(i);
    thermal_regbank_limit u_lim (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .wr_i  (wr_en_i && addr_i == LADDR),
      .lock_i((i == N_LIMITS - 1) ? cfg.crit_lock : cfg.alarm_lock),
      .wd_i  (wr_data_i),
      .q_o   (lim_q[i])
    );
  end

  thermal_regbank_sample u_smp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (sample_valid_i),
    .shdn_i  (cfg.shdn),
    .sample_i(sample_i),
    .flags_i ({crit_trip_i, high_trip_i, low_trip_i}),
    .q_o     (temp_q)
  );

  assign cfg_rd = {5'b0, cfg.hyst, cfg.shdn, cfg.crit_lock, cfg.alarm_lock, 1'b0,
                   event_active_i, cfg.ev_en, cfg.crit_only, cfg.ev_pol, cfg.ev_mode};

  always_comb begin
    unique case (addr_i)
      A_CAP:   rd_data_o = CAP_VAL;
      A_CFG:   rd_data_o = cfg_rd;
      A_HIGH:  rd_data_o = lim_q[0];
      A_LOW:   rd_data_o = lim_q[1];
      A_CRIT:  rd_data_o = lim_q[2];
      A_TEMP:  rd_data_o = temp_q;
      A_MFR:   rd_data_o = MFR_VAL;
      A_DEV:   rd_data_o = DEV_VAL;
      default: rd_data_o = '0;
    endcase
  end

  assign hyst_o       = cfg.hyst;
  assign shutdown_o   = cfg.shdn;
  assign crit_lock_o  = cfg.crit_lock;
  assign alarm_lock_o = cfg.alarm_lock;
  assign event_en_o   = cfg.ev_en;
  assign crit_only_o  = cfg.crit_only;
  assign event_pol_o  = cfg.ev_pol;
  assign event_mode_o = cfg.ev_mode;
  assign high_limit_o = lim_q[0];
  assign low_limit_o  = lim_q[1];
  assign crit_limit_o = lim_q[2];
endmodule

// File: rtl/thermal_regbank_chk.sv
module thermal_regbank_chk
  import thermal_regbank_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              shutdown_o,
  input logic              crit_lock_o,
  input logic              alarm_lock_o,
  input logic [1:0]        hyst_o,
  input logic              event_en_o,
  input logic              event_pol_o,
  input logic              event_mode_o,
  input logic              crit_only_o,
  input logic [DATA_W-1:0] high_limit_o,
  input logic [DATA_W-1:0] low_limit_o,
  input logic [DATA_W-1:0] crit_limit_o
);
  AST_LIMIT_ZERO_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((high_limit_o | low_limit_o | crit_limit_o) & ~LIMIT_MASK) == '0); // R2
  AST_ALARM_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_lock_o |=> alarm_lock_o && $stable(high_limit_o) && $stable(low_limit_o)); // R3
  AST_CRIT_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crit_lock_o |=> crit_lock_o && $stable(crit_limit_o)); // R4
  AST_FIELDS_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (crit_lock_o || alarm_lock_o) |=> $stable(hyst_o) && $stable(event_en_o)
      && $stable(event_pol_o) && $stable(event_mode_o)); // R5
  AST_CRIT_ONLY_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alarm_lock_o && !crit_only_o) |=> !crit_only_o); // R6
  AST_SHDN_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((crit_lock_o || alarm_lock_o) && !shutdown_o) |=> !shutdown_o); // R7
  AST_CLEAR_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_CFG) |-> (rd_data_o[5] == 1'b0 && rd_data_o[15:11] == '0)); // R8
  AST_TEMP_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shutdown_o && addr_i == A_TEMP) |=> (addr_i != A_TEMP || $stable(rd_data_o))); // R11
endmodule

bind thermal_regbank thermal_regbank_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .rd_data_o   (rd_data_o),
  .shutdown_o  (shutdown_o),
  .crit_lock_o (crit_lock_o),
  .alarm_lock_o(alarm_lock_o),
  .hyst_o      (hyst_o),
  .event_en_o  (event_en_o),
  .event_pol_o (event_pol_o),
  .event_mode_o(event_mode_o),
  .crit_only_o (crit_only_o),
  .high_limit_o(high_limit_o),
  .low_limit_o (low_limit_o),
  .crit_limit_o(crit_limit_o)
);

// File: tb/thermal_regbank_bench.sv
module thermal_regbank_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic [15:0] rd_data_o;
  logic        sample_valid_i = 1'b0;
  logic [12:0] sample_i = '0;
  logic        crit_trip_i = 1'b0, high_trip_i = 1'b0, low_trip_i = 1'b0;
  logic        event_active_i = 1'b0;
  logic [1:0]  hyst_o;
  logic        shutdown_o, crit_lock_o, alarm_lock_o, event_en_o;
  logic        crit_only_o, event_pol_o, event_mode_o, event_clear_o;
  logic [15:0] high_limit_o, low_limit_o, crit_limit_o;

  int errors = 0;
  int checks = 0;

  thermal_regbank u_thermal_regbank (.*);

  always #5 clk_i = ~clk_i;

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: expired, got hang expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(input logic [15:0] got, input logic [15:0] exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk_i);
    addr_i = a; wr_data_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    addr_i = a;
    #1 d = rd_data_o;
  endtask

  function automatic logic [15:0] reset_val(input int a);
    case (a)
      0: return 16'h007F;
      6: return 16'h1B09;
      7: return 16'h0813;
      default: return 16'h0000;
    endcase
  endfunction

  logic [15:0] v;

  initial begin
    do_reset();
    // R1 reset map
    for (int a = 0; a < 256; a += 3) begin
      rd(8'(a), v); chk(v, reset_val(a), "R1");
    end
    for (int a = 0; a < 8; a++) begin
      rd(8'(a), v); chk(v, reset_val(a), "R1");
    end

    // R2 limit masking sweep
    for (int k = 0; k < 64; k++) begin
      logic [15:0] pat;
      pat = 16'(k * 16'h0403 + 16'hA005);
      for (int a = 2; a <= 4; a++) begin
        wr(8'(a), pat);
        rd(8'(a), v); chk(v, pat & 16'h1FFC, "R2");
      end
    end

    // R12 read-only and reserved writes
    wr(8'h00, 16'hFFFF); wr(8'h06, 16'h0000); wr(8'h07, 16'hFFFF);
    wr(8'h05, 16'hBEEF); wr(8'h08, 16'hFFFF); wr(8'hFF, 16'h1234);
    for (int a = 0; a < 10; a++) begin
      if (a >= 1 && a <= 4) continue;
      rd(8'(a), v); chk(v, (a == 8) ? 16'h0 : reset_val(a), "R12");
    end
    rd(8'hFF, v); chk(v, 16'h0, "R12");

    // R9 status bit and reserved high bits
    wr(8'h01, 16'hF800 | 16'h060B);
    event_active_i = 1'b1;
    rd(8'h01, v); chk(v, 16'h061B, "R9");
    event_active_i = 1'b0;
    rd(8'h01, v); chk(v, 16'h060B, "R9");

    // R8 clear strobe
    @(negedge clk_i);
    addr_i = 8'h01; wr_data_i = 16'h0020; wr_en_i = 1'b1;
    #1 chk({15'b0, event_clear_o}, 16'h0, "R8");
    @(negedge clk_i);
    wr_en_i = 1'b0;
    chk({15'b0, event_clear_o}, 16'h1, "R8");
    rd(8'h01, v); chk(v & 16'h0020, 16'h0, "R8");
    @(negedge clk_i);
    chk({15'b0, event_clear_o}, 16'h0, "R8");

    // R10 sample capture sweep, R11 shutdown freeze
    wr(8'h01, 16'h0000);
    for (int s = 0; s < 8192; s += 97) begin
      @(negedge clk_i);
      sample_valid_i = 1'b1; sample_i = 13'(s);
      {crit_trip_i, high_trip_i, low_trip_i} = 3'(s);
      @(negedge clk_i);
      sample_valid_i = 1'b0;
      rd(8'h05, v); chk(v, {3'(s), 13'(s)}, "R10");
    end
    wr(8'h01, 16'h0100);
    chk({15'b0, shutdown_o}, 16'h1, "R11");
    @(negedge clk_i);
    sample_valid_i = 1'b1; sample_i = 13'h0ABC; {crit_trip_i, high_trip_i, low_trip_i} = 3'b000;
    @(negedge clk_i);
    sample_valid_i = 1'b0;
    rd(8'h05, v); chk(v, {3'(8148), 13'(8148)}, "R11");
    wr(8'h01, 16'h0000);
    @(negedge clk_i);
    sample_valid_i = 1'b1; sample_i = 13'h1C90; {crit_trip_i, high_trip_i, low_trip_i} = 3'b001;
    @(negedge clk_i);
    sample_valid_i = 1'b0;
    rd(8'h05, v); chk(v, 16'h3C90, "R10");

    // R3 alarm lock
    do_reset();
    wr(8'h02, 16'h0320); wr(8'h03, 16'h0190); wr(8'h04, 16'h07D0);
    wr(8'h01, 16'h0645);            // hyst=3, lock6, crit_only, mode
    wr(8'h01, 16'h0000);            // try to clear everything
    rd(8'h01, v); chk(v, 16'h0641, "R3 R5 R6");
    wr(8'h02, 16'h1FFC); wr(8'h03, 16'h1FFC);
    rd(8'h02, v); chk(v, 16'h0320, "R3");
    rd(8'h03, v); chk(v, 16'h0190, "R3");
    wr(8'h04, 16'h0AAC);
    rd(8'h04, v); chk(v, 16'h0AAC, "R4");
    wr(8'h01, 16'h0104);            // try set shutdown and crit_only
    rd(8'h01, v); chk(v, 16'h0641, "R6 R7");

    // R4 critical lock, R7 shutdown cleared while locked
    do_reset();
    wr(8'h01, 16'h0100);            // shutdown, no lock
    wr(8'h01, 16'h0180);            // set crit lock, keep shutdown
    rd(8'h01, v); chk(v, 16'h0180, "R4");
    wr(8'h01, 16'h0000);            // clear shutdown allowed
    rd(8'h01, v); chk(v, 16'h0080, "R7");
    wr(8'h01, 16'h010F);            // set nothing but crit_only
    rd(8'h01, v); chk(v, 16'h0084, "R5 R6");
    wr(8'h04, 16'h0500);
    rd(8'h04, v); chk(v, 16'h0000, "R4");
    wr(8'h02, 16'h0400);
    rd(8'h02, v); chk(v, 16'h0400, "R3");
    wr(8'h01, 16'h0040);            // add alarm lock, crit_only cleared
    rd(8'h01, v); chk(v, 16'h00C0, "R6");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule